// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block turns one cache maintenance request into the series of queue commands that carries it out. A request gives a start address, an end address and an operation code (invalidate, clean or flush). The start is moved down to a line boundary. The byte count from there to the end is rounded up to whole lines. That count is then cut into range commands, none larger than a configured ceiling. Each command goes to an external maintenance queue through a valid/acknowledge handshake.

The queue may refuse a registration, for example when it is full or busy with another master. A refused command is offered again on its own. The sequencer waits for the queue's completion pulse after each accepted range command before it offers the next one. When the last range command has completed, it sends a sync command. A request whose span would reach nearly the whole address space is replaced by one whole-cache command, also followed by a sync.

Line size, address width and the per-command range limit are parameters. The largest command covers the range limit less one line.

Top module: `cache_range_seq`

## Requirements
- R1: While reset is asserted, `busy`, `done` and `cmd_valid` are all low.
- R2: The first range command of a request carries the start address rounded down to a multiple of LINE_BYTES, and every range command address has its low log2(LINE_BYTES) bits at zero.
- R3: The range commands of one request cover, in total, (end minus aligned start) rounded up to a multiple of LINE_BYTES, with each command length a whole number of lines.
- R4: Each range command length equals the smaller of the bytes still uncovered and RANGE_LIMIT minus LINE_BYTES, and each command begins where the previous one ended (modulo 2^ADDR_W).
- R5: If (end minus aligned start) modulo 2^ADDR_W is at least 2^ADDR_W minus LINE_BYTES, exactly one command of kind 1 (whole cache) is issued in place of range commands, with address and length zero.
- R6: When `cmd_ack` arrives with `cmd_reject` high on a range or whole-cache command, `cmd_valid` drops for one cycle and the same command is offered again. While `cmd_valid` is high and unacknowledged, kind, address, length and operation hold steady.
- R7: After a range or whole-cache command is accepted, no further command is offered until a `cmp_done` pulse arrives. A `cmp_done` pulse that arrives while a command is still being offered is ignored.
- R8: The last command of every request is a sync (kind 2, address and length zero). `done` rises only in the cycle after that sync is acknowledged. Kind 0 means range, and kind 3 is never offered.
- R9: A request whose aligned span is zero bytes issues no range command and only the sync.
- R10: `busy` is high from the cycle after a request is accepted until the sync is acknowledged. `done` is a single-cycle pulse in the cycle after the sync is acknowledged. A `req_valid` seen while busy is ignored.
- R11: Every range and whole-cache command carries the operation code of the request that produced it (0 invalidate, 1 clean, 2 flush).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_start | input | ADDR_W | First byte address of the request |
| req_end | input | ADDR_W | Address just past the request |
| req_op | input | 2 | Operation code |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when the request's sync is acknowledged |
| cmd_valid | output | 1 | Command offered to the queue |
| cmd_kind | output | 2 | 0 range, 1 whole cache, 2 sync |
| cmd_op | output | 2 | Operation code of the command |
| cmd_addr | output | ADDR_W | Range start (zero for other kinds) |
| cmd_size | output | ADDR_W | Range length in bytes (zero for other kinds) |
| cmd_ack | input | 1 | Queue has taken the offered command |
| cmd_reject | input | 1 | With `cmd_ack`: registration refused, retry |
| cmp_done | input | 1 | Completion pulse for the last accepted command |

## Verification
Checked on every cycle:
- Command fields hold steady while a command is offered.
- `cmd_valid` drops for one cycle after a refused registration.
- Every range command is line-aligned and within the length ceiling.
- A whole-cache command carries zero address and length.
- `done` is a single pulse caused by a sync acknowledgement.
- Nothing is offered while waiting for completion or when idle.

The bench's sweeps are needed for the rest:
- the exact chunk addresses and lengths;
- the byte totals after rounding;
- the threshold that promotes a request to a whole-cache command;
- the wrap-around of addresses;
- the operation code carried on each command.

The bench's sweeps also show that early completion pulses are discarded and that requests made while busy leave the command stream unchanged.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [1:0] {
    CK_RANGE = 2'd0,
    CK_ALL   = 2'd1,
    CK_SYNC  = 2'd2
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_RETRY = 3'd2,
    ST_WAIT  = 3'd3,
    ST_SYNC  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/cms_reset_sync.sv
module cms_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/cms_range_planner.sv
module cms_range_planner #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] bytes_o,
  output logic              whole_o,
  output logic              empty_o
);

  // offset mask within one line; its complement is also -LINE_BYTES
  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] span;

  always_comb begin
    base_o  = start_i & ~LMASK;
    span    = end_i - base_o;
    whole_o = (span >= ~LMASK);
    bytes_o = (span + LMASK) & ~LMASK;
    empty_o = (bytes_o == '0);
  end

endmodule

// File: rtl/cms_chunk_track.sv
module cms_chunk_track #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int RANGE_LIMIT = 1 << 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_base_i,
  input  logic [ADDR_W-1:0] load_bytes_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] cur_len_o,
  output logic              drained_o
);

  localparam int                LB      = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] MAX_LEN = ADDR_W'(RANGE_LIMIT - LINE_BYTES);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] rem_q, rem_d;
  logic              upd_en;

  always_comb begin
    cur_len_o = (rem_q < MAX_LEN) ? rem_q : MAX_LEN;
    upd_en    = load_i | step_i;
    if (load_i) begin
      addr_d = load_base_i;
      rem_d  = load_bytes_i;
    end else begin
      addr_d = addr_q + cur_len_o;
      rem_d  = rem_q - cur_len_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign cur_addr_o = addr_q;
  assign drained_o  = (rem_q == '0);

  // R4: a consumed chunk is never empty and never above the ceiling
  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cur_len_o != '0) && (cur_len_o <= MAX_LEN));

  // R3: every consumed chunk is a whole number of lines
  p_len_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cur_len_o[LB-1:0] == '0));

  // R2: chunk addresses stay on line boundaries
  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cur_addr_o[LB-1:0] == '0));

  // R4: no step is taken once the span is used up
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !drained_o);

endmodule

// File: rtl/cms_seq_ctrl.sv
module cms_seq_ctrl
  import cms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  input  logic [1:0] req_op_i,
  input  logic       plan_whole_i,
  input  logic       plan_empty_i,
  input  logic       drained_i,
  input  logic       cmd_ack_i,
  input  logic       cmd_reject_i,
  input  logic       cmp_done_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       cmd_valid_o,
  output cmd_kind_e  cmd_kind_o,
  output logic [1:0] cmd_op_o,
  output logic       load_o,
  output logic       step_o
);

  seq_state_e state_q, state_d;
  logic       whole_q;
  logic [1:0] op_q;
  logic       cmp_flag_q, cmp_flag_d;
  logic       done_q, done_d;
  logic       accept;

  // next-state and command decode
  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    step_o      = 1'b0;
    cmd_valid_o = 1'b0;
    cmd_kind_o  = CK_RANGE;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          load_o = 1'b1;
          if (plan_whole_i)      state_d = ST_ISSUE;
          else if (plan_empty_i) state_d = ST_SYNC;
          else                   state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cmd_valid_o = 1'b1;
        cmd_kind_o  = whole_q ? CK_ALL : CK_RANGE;
        if (cmd_ack_i) begin
          if (cmd_reject_i) begin
            state_d = ST_RETRY;
          end else begin
            step_o  = !whole_q;
            state_d = ST_WAIT;
          end
        end
      end
      ST_RETRY: state_d = ST_ISSUE;
      ST_WAIT: begin
        if (cmp_flag_q) state_d = (whole_q || drained_i) ? ST_SYNC : ST_ISSUE;
      end
      ST_SYNC: begin
        cmd_valid_o = 1'b1;
        cmd_kind_o  = CK_SYNC;
        if (cmd_ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // completion flag: cleared outside the wait state, so early pulses are lost
  always_comb begin
    accept = (state_q == ST_IDLE) && req_valid_i;
    if (state_q == ST_WAIT) cmp_flag_d = cmp_flag_q ? 1'b0 : cmp_done_i;
    else                    cmp_flag_d = 1'b0;
    done_d = (state_q == ST_SYNC) && cmd_ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cmp_flag_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cmp_flag_q <= cmp_flag_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whole_q <= 1'b0;
      op_q    <= 2'd0;
    end else if (accept) begin
      whole_q <= plan_whole_i;
      op_q    <= req_op_i;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign cmd_op_o = op_q;

  // R7: while waiting with no completion recorded, nothing is offered next cycle
  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) && !cmp_flag_q |=> !cmd_valid_o);

  // R10: a request is only taken while idle
  p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> busy_o);

endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int RANGE_LIMIT = 1 << 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [1:0]        req_op,
  output logic              busy,
  output logic              done,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_size,
  input  logic              cmd_ack,
  input  logic              cmd_reject,
  input  logic              cmp_done
);

  import cms_pkg::*;

  logic              srst_n;
  logic [ADDR_W-1:0] plan_base, plan_bytes;
  logic              plan_whole, plan_empty;
  logic [ADDR_W-1:0] chunk_addr, chunk_len;
  logic              drained, load, step;
  cmd_kind_e         kind_e;

  cms_reset_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cms_range_planner #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_plan (
    .start_i (req_start),
    .end_i   (req_end),
    .base_o  (plan_base),
    .bytes_o (plan_bytes),
    .whole_o (plan_whole),
    .empty_o (plan_empty)
  );

  cms_chunk_track #(
    .ADDR_W      (ADDR_W),
    .LINE_BYTES  (LINE_BYTES),
    .RANGE_LIMIT (RANGE_LIMIT)
  ) u_chunk (
    .clk          (clk),
    .rst_n        (srst_n),
    .load_i       (load),
    .load_base_i  (plan_base),
    .load_bytes_i (plan_bytes),
    .step_i       (step),
    .cur_addr_o   (chunk_addr),
    .cur_len_o    (chunk_len),
    .drained_o    (drained)
  );

  cms_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (srst_n),
    .req_valid_i  (req_valid),
    .req_op_i     (req_op),
    .plan_whole_i (plan_whole),
    .plan_empty_i (plan_empty),
    .drained_i    (drained),
    .cmd_ack_i    (cmd_ack),
    .cmd_reject_i (cmd_reject),
    .cmp_done_i   (cmp_done),
    .busy_o       (busy),
    .done_o       (done),
    .cmd_valid_o  (cmd_valid),
    .cmd_kind_o   (kind_e),
    .cmd_op_o     (cmd_op),
    .load_o       (load),
    .step_o       (step)
  );

  always_comb begin
    cmd_kind = kind_e;
    if (kind_e == CK_RANGE) begin
      cmd_addr = chunk_addr;
      cmd_size = chunk_len;
    end else begin
      cmd_addr = '0;
      cmd_size = '0;
    end
  end

  // R6: an offered command does not change until acknowledged
  p_fields_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr)
                              && $stable(cmd_size) && $stable(cmd_op));

  // R6: a refused registration leaves one idle cycle before the retry
  p_retry_gap_r6: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_valid && cmd_ack && cmd_reject && (cmd_kind != 2'd2) |=> !cmd_valid);

  // R5: whole-cache commands carry no address or length
  p_whole_zero_r5: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_valid && (cmd_kind == 2'd1) |-> (cmd_addr == '0) && (cmd_size == '0));

  // R8: only the three defined kinds are offered
  p_kind_legal_r8: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_valid |-> (cmd_kind != 2'd3));

  // R8: done is caused by an acknowledged sync
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> $past(cmd_valid && cmd_ack && (cmd_kind == 2'd2)));

  // R10: done lasts a single cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);

  // R10: nothing is offered while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |-> !cmd_valid);

endmodule

// File: tb/test_cache_range_seq.sv
`timescale 1ns/1ps
module test_cache_range_seq;

  localparam int AW     = 10;
  localparam int LBYTES = 16;
  localparam int LIM    = 64;
  localparam int MAXC   = LIM - LBYTES;
  localparam int ASPACE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_start, req_end;
  logic [1:0]    req_op;
  logic          busy, done, cmd_valid;
  logic [1:0]    cmd_kind, cmd_op;
  logic [AW-1:0] cmd_addr, cmd_size;
  logic          cmd_ack, cmd_reject, cmp_done;

  always #2.5 clk = ~clk;

  cache_range_seq #(.ADDR_W(AW), .LINE_BYTES(LBYTES), .RANGE_LIMIT(LIM)) i_cache_range_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
    .req_end(req_end), .req_op(req_op), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_ack(cmd_ack),
    .cmd_reject(cmd_reject), .cmp_done(cmp_done)
  );

  int n_chk, n_bad;
  int ek[0:63], ea[0:63], es[0:63];
  int exp_n, exp_total, idx, sum_acc, att, cmp_wait, cur_op;
  int rej_k, rej_a, rej_s;
  bit awaiting, expect_done, run_done, spur_done, prev_rej;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input int k, input int a, input int s);
    ek[exp_n] = k; ea[exp_n] = a; es[exp_n] = s;
    exp_n++;
  endtask

  // expected command list, from the requirements' arithmetic
  task automatic plan(input int s, input int e);
    int al, sz, r, a, c;
    exp_n = 0;
    al = s & ~(LBYTES - 1);
    sz = (e - al) & (ASPACE - 1);
    if (sz >= ASPACE - LBYTES) begin
      exp_total = 0;
      push(1, 0, 0);
    end else begin
      r = (sz + LBYTES - 1) & ~(LBYTES - 1);
      exp_total = r;
      a = al;
      while (r > 0) begin
        c = (r < MAXC) ? r : MAXC;
        push(0, a, c);
        a = (a + c) % ASPACE;
        r -= c;
      end
    end
    push(2, 0, 0);
  endtask

  // queue model and output checks, once per falling edge
  task automatic mon_step();
    if (expect_done) begin
      chk(done === 1'b1, "R10 done pulse", int'(done), 1);
      chk(busy === 1'b0, "R10 busy release", int'(busy), 0);
      chk(idx == exp_n, (exp_n == 1) ? "R9 command count" : "R8 command count", idx, exp_n);
      chk(sum_acc == exp_total, "R3 byte total", sum_acc, exp_total);
      expect_done = 0;
      run_done = 1;
    end else if (done === 1'b1) begin
      chk(1'b0, "R10 stray done", 1, 0);
    end
    cmp_done = 1'b0;
    if (cmp_wait > 0) begin
      cmp_wait--;
      if (cmp_wait == 0) begin
        cmp_done = 1'b1;
        awaiting = 0;
      end
    end
    if (cmd_ack) begin
      cmd_ack = 1'b0;
      cmd_reject = 1'b0;
    end else if (cmd_valid === 1'b1) begin
      if (cmd_kind != 2'd2 && !spur_done && (att % 4 == 0)) begin
        cmp_done = 1'b1;   // R7: early pulse must be discarded
        spur_done = 1;
      end else begin
        spur_done = 0;
        chk(!awaiting, "R7 offered before completion", int'(awaiting), 0);
        if (prev_rej)
          chk(int'(cmd_kind) == rej_k && int'(cmd_addr) == rej_a && int'(cmd_size) == rej_s,
              "R6 reissue address", int'(cmd_addr), rej_a);
        if (idx >= exp_n) begin
          chk(1'b0, "R8 extra command", idx, exp_n);
        end else begin
          chk(int'(cmd_kind) == ek[idx],
              (ek[idx] == 1) ? "R5 kind" : (ek[idx] == 2) ? "R8 kind" : "R2 kind",
              int'(cmd_kind), ek[idx]);
          chk(int'(cmd_addr) == ea[idx], (idx == 0) ? "R2 first address" : "R4 chunk address",
              int'(cmd_addr), ea[idx]);
          chk(int'(cmd_size) == es[idx], "R4 chunk size", int'(cmd_size), es[idx]);
          if (ek[idx] != 2) chk(int'(cmd_op) == cur_op, "R11 op code", int'(cmd_op), cur_op);
        end
        cmd_ack = 1'b1;
        if (cmd_kind == 2'd2) begin
          idx++;
          expect_done = 1;
          prev_rej = 0;
        end else begin
          cmd_reject = (att % 3 == 1);
          att++;
          prev_rej = cmd_reject;
          rej_k = int'(cmd_kind); rej_a = int'(cmd_addr); rej_s = int'(cmd_size);
          if (!cmd_reject) begin
            idx++;
            if (cmd_kind == 2'd0) sum_acc += int'(cmd_size);
            awaiting = 1;
            cmp_wait = 1 + (att % 3);
          end
        end
      end
    end
  endtask

  task automatic run(input int s, input int e, input int op);
    int cyc;
    plan(s, e);
    idx = 0; sum_acc = 0; run_done = 0; cur_op = op;
    @(negedge clk);
    req_valid = 1'b1;
    req_start = AW'(s); req_end = AW'(e); req_op = 2'(op);
    cyc = 0;
    while (!run_done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        req_valid = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
      end
      if (cyc == 2 && exp_n >= 2) begin
        // R10: a request while busy must not disturb the stream
        req_valid = 1'b1; req_start = AW'(5); req_end = AW'(900); req_op = 2'd3;
      end
      if (cyc == 3) req_valid = 1'b0;
      mon_step();
    end
    if (!run_done) chk(1'b0, "R8 watchdog: sync never completed", cyc, 0);
  endtask

  initial begin
    int offs[11];
    int hoff[6];
    int hst[4];
    int nrun;
    offs = '{0, 1, 15, 16, 17, 47, 48, 49, 95, 97, 200};
    hoff = '{990, 1000, 1007, 1008, 1015, 1020};
    hst  = '{0, 5, 16, 33};
    n_chk = 0; n_bad = 0; att = 0; cmp_wait = 0;
    awaiting = 0; expect_done = 0; spur_done = 0; prev_rej = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_start = '0; req_end = '0; req_op = '0;
    cmd_ack = 1'b0; cmd_reject = 1'b0; cmp_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done === 1'b0, "R1 done in reset", int'(done), 0);
    chk(cmd_valid === 1'b0, "R1 cmd_valid in reset", int'(cmd_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nrun = 0;
    for (int s = 0; s < 48; s++) begin
      for (int j = 0; j < 11; j++) begin
        run(s, (s + offs[j]) % ASPACE, nrun % 3);
        nrun++;
      end
    end
    // near-full spans: threshold of R5 and wrap-around of R4
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 6; j++) begin
        run(hst[i], (hst[i] + hoff[j]) % ASPACE, nrun % 3);
        nrun++;
      end
    end
    // end below the aligned start
    run(40, 20, 2);
    run(40, 10, 1);
    run(1000, 4, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule